// File: doc/BRIEF.md
# Clock Generator Configuration Register Bank

This block holds the control state of a motherboard clock generator in 32 byte-wide registers. A serial slave front end, not part of this block, turns bus transactions into single-cycle byte writes and combinational byte reads. The register contents are decoded continuously into named control fields for the output gating and synthesizer logic:

- frequency code and its source
- spread-spectrum enable and mode
- tri-state request
- per-output enables
- stop masks
- peripheral clock rate select
- PLL divider values
- clamped skew codes

When reset is released, the block captures four strap pins once. Depending on a mode bit, the 5-bit frequency code comes either from these captured pins or from five bits spread across the control byte at address 4. One byte reports the captured straps, another holds a fixed identification value, and every reserved bit keeps its reset value no matter what is written.

Top module: `clkcfg_regbank`

## Requirements
- R1: After reset the bytes read:
  - 0x00 to 0x03: 0xFF
  - 0x04: 0x00
  - 0x06: 0x0B
  - 0x07: 0xFF
  - 0x09: 0xB0
  - 0x0A: 0x7F
  - 0x0B: 0x3F
  - 0x12: 0x44
  - 0x13: 0x40
  - every other defined byte from 0x00 to 0x16 that is not address 0x05 or 0x08: 0x00
- R2: A write with `wr_en` high updates, at the next rising clock edge, only the writable bits of the addressed byte. The writable masks are:
  - 0x04: 0xFF
  - 0x06: 0x3F
  - 0x07: 0xFF
  - 0x09: 0xB9
  - 0x0A: 0x7F
  - 0x0D: 0x07
  - 0x0E: 0xFF
  - 0x0F: 0x7F
  - 0x12: 0xFF
  - all other bytes: 0x00

  A masked-off bit always reads its R1 reset value.
- R3: Byte 0x05 reads {4'b0000, captured straps[3:0]}, and writes to it change nothing.
- R4: The straps are captured at the first rising edge after reset is released and are held unchanged until the next reset.
- R5: Byte 0x08 always reads 0xF1, and writes to it are ignored.
- R6: `freq_from_regs` is byte 0x04 bit 3. When it is 0, `freq_code` = {0, captured straps}. When it is 1, `freq_code` = {b4[2], b4[7:4]}.
- R7: `ssc_en` is the inverse of byte 0x04 bit 1 (a 1 in that bit turns spread off). `out_tristate` equals byte 0x04 bit 0.
- R8: Byte 0x09 drives four outputs:
  - bit 7: `pd_pin_en`
  - bits 5 and 4: `usb_oe` and `sio_oe`
  - bit 3: `periph_48m` (0 selects 24 MHz, 1 selects 48 MHz)
  - bit 0: `spread_down` (0 selects ±0.25 % center spread, 1 selects 0 to -0.5 % down spread)
- R9: Byte 0x06 drives the stop masks and CPU enables:
  - bit 5: `pcif0_stop_mask`
  - bit 4: `pcif1_stop_mask`
  - bit 3: `cpu0_stop_mask`
  - bit 2: `cpu1_stop_mask`
  - bit 1: `cpu0_oe`
  - bit 0: `cpu1_oe`
- R10: `pci_oe` equals byte 0x07. `aux_oe` equals byte 0x0A bits 6:0.
- R11: `pll_n` = {b13[1:0], b14[7:0]}, `pll_m` = b15[6:0], and `pll_from_div` = b13[2].
- R12: `cpu0_skew` comes from byte 0x12 bits 7:4 and `cpu1_skew` from bits 3:0. Each is clamped to 8 (code 1000, which is 2000 ps delay); codes 0 to 8 pass through unchanged.
- R13: Addresses 0x17 to 0x1F read 0x00, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strap_in | input | 4 | Frequency strap pins |
| wr_en | input | 1 | Byte write strobe |
| addr | input | 5 | Byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr (combinational) |
| freq_code | output | 5 | Effective frequency code |
| freq_from_regs | output | 1 | Frequency code source is the register |
| ssc_en | output | 1 | Spread spectrum active |
| out_tristate | output | 1 | Float every clock output |
| spread_down | output | 1 | Down-spread mode |
| periph_48m | output | 1 | Peripheral clock at 48 MHz |
| pd_pin_en | output | 1 | Power-down pin honoured |
| usb_oe | output | 1 | Fixed 48 MHz output enable |
| sio_oe | output | 1 | Selectable 24/48 MHz output enable |
| cpu0_stop_mask | output | 1 | CPU pair 0 follows stop pin |
| cpu1_stop_mask | output | 1 | CPU clock 1 follows stop pin |
| cpu0_oe | output | 1 | CPU pair 0 enable |
| cpu1_oe | output | 1 | CPU clock 1 enable |
| pcif0_stop_mask | output | 1 | Free-running PCI 0 follows stop pin |
| pcif1_stop_mask | output | 1 | Free-running PCI 1 follows stop pin |
| pci_oe | output | 8 | PCI output enables |
| aux_oe | output | 7 | AGP, link, reference and interrupt-controller clock enables |
| pll_n | output | 10 | PLL feedback divider |
| pll_m | output | 7 | PLL reference divider |
| pll_from_div | output | 1 | PLL uses divider registers |
| cpu0_skew | output | 4 | Clamped skew code, CPU pair 0 |
| cpu1_skew | output | 4 | Clamped skew code, CPU clock 1 |

## Verification
The hardest state to reach from the ports is strap capture. The straps are visible only in the single cycle after reset is released, and they feed the frequency code only while the mode bit is 0. The bench sets a strap pattern during reset and inverts the pins right after capture, so it can observe that the held value stays put. It then re-resets with the complementary pattern and sweeps every address with several data patterns, which separates capture at release from continuous tracking of the pins. Exhaustive skew sweeps over all 16 codes on both nibbles show the clamp boundary.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;
  localparam int unsigned STRAP_ADDR = 5;
  localparam int unsigned ID_ADDR    = 8;
  localparam logic [3:0]  SKEW_MAX   = 4'd8;

  function automatic logic [7:0] byte_rst(int unsigned a);
    case (a)
      0, 1, 2, 3: return 8'hFF;
      6:          return 8'h0B;
      7:          return 8'hFF;
      8:          return 8'hF1;
      9:          return 8'hB0;
      10:         return 8'h7F;
      11:         return 8'h3F;
      18:         return 8'h44;
      19:         return 8'h40;
      default:    return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] byte_wmask(int unsigned a);
    case (a)
      4:       return 8'hFF;
      6:       return 8'h3F;
      7:       return 8'hFF;
      9:       return 8'hB9;
      10:      return 8'h7F;
      13:      return 8'h07;
      14:      return 8'hFF;
      15:      return 8'h7F;
      18:      return 8'hFF;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [3:0] skew_clamp(logic [3:0] c);
    return (c > SKEW_MAX) ? SKEW_MAX : c;
  endfunction

  function automatic logic [4:0] freq_pick(logic from_regs, logic [7:0] ctl,
                                           logic [3:0] strap);
    return from_regs ? {ctl[2], ctl[7:4]} : {1'b0, strap};
  endfunction
endpackage

// File: rtl/clkcfg_strap_capture.sv
module clkcfg_strap_capture #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pins,
  output logic [W-1:0] held,
  output logic         taken
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held  <= '0;
      taken <= 1'b0;
    end else if (!taken) begin
      held  <= pins;
      taken <= 1'b1;
    end
  end
endmodule

// File: rtl/clkcfg_reg_byte.sv
module clkcfg_reg_byte #(
  parameter logic [7:0] RST  = 8'h00,
  parameter logic [7:0] MASK = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [7:0] wd,
  output logic [7:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= RST;
    else if (we) q <= (wd & MASK) | (RST & ~MASK);
  end
endmodule

// File: rtl/clkcfg_field_map.sv
module clkcfg_field_map
  import clkcfg_pkg::*;
(
  input  logic [7:0] ctl4,
  input  logic [5:0] stopc,
  input  logic [7:0] pcien,
  input  logic [4:0] perif,
  input  logic [6:0] auxen,
  input  logic [2:0] divc,
  input  logic [7:0] nlo,
  input  logic [6:0] mdiv,
  input  logic [7:0] skew,
  input  logic [3:0] strap,
  output logic [4:0] freq_code,
  output logic       freq_from_regs,
  output logic       ssc_en,
  output logic       out_tristate,
  output logic       spread_down,
  output logic       periph_48m,
  output logic       pd_pin_en,
  output logic       usb_oe,
  output logic       sio_oe,
  output logic       cpu0_stop_mask,
  output logic       cpu1_stop_mask,
  output logic       cpu0_oe,
  output logic       cpu1_oe,
  output logic       pcif0_stop_mask,
  output logic       pcif1_stop_mask,
  output logic [7:0] pci_oe,
  output logic [6:0] aux_oe,
  output logic [9:0] pll_n,
  output logic [6:0] pll_m,
  output logic       pll_from_div,
  output logic [3:0] cpu0_skew,
  output logic [3:0] cpu1_skew
);
  always_comb begin
    freq_from_regs  = ctl4[3];
    freq_code       = freq_pick(ctl4[3], ctl4, strap);
    ssc_en          = ~ctl4[1];
    out_tristate    = ctl4[0];
    pd_pin_en       = perif[4];
    usb_oe          = perif[3];
    sio_oe          = perif[2];
    periph_48m      = perif[1];
    spread_down     = perif[0];
    pcif0_stop_mask = stopc[5];
    pcif1_stop_mask = stopc[4];
    cpu0_stop_mask  = stopc[3];
    cpu1_stop_mask  = stopc[2];
    cpu0_oe         = stopc[1];
    cpu1_oe         = stopc[0];
    pci_oe          = pcien;
    aux_oe          = auxen;
    pll_from_div    = divc[2];
    pll_n           = {divc[1:0], nlo};
    pll_m           = mdiv;
    cpu0_skew       = skew_clamp(skew[7:4]);
    cpu1_skew       = skew_clamp(skew[3:0]);
  end
endmodule

// File: rtl/clkcfg_regbank.sv
module clkcfg_regbank
  import clkcfg_pkg::*;
#(
  parameter int unsigned AW      = 5,
  parameter int unsigned STRAP_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [STRAP_W-1:0] strap_in,
  input  logic               wr_en,
  input  logic [AW-1:0]      addr,
  input  logic [7:0]         wdata,
  output logic [7:0]         rdata,
  output logic [4:0]         freq_code,
  output logic               freq_from_regs,
  output logic               ssc_en,
  output logic               out_tristate,
  output logic               spread_down,
  output logic               periph_48m,
  output logic               pd_pin_en,
  output logic               usb_oe,
  output logic               sio_oe,
  output logic               cpu0_stop_mask,
  output logic               cpu1_stop_mask,
  output logic               cpu0_oe,
  output logic               cpu1_oe,
  output logic               pcif0_stop_mask,
  output logic               pcif1_stop_mask,
  output logic [7:0]         pci_oe,
  output logic [6:0]         aux_oe,
  output logic [9:0]         pll_n,
  output logic [6:0]         pll_m,
  output logic               pll_from_div,
  output logic [3:0]         cpu0_skew,
  output logic [3:0]         cpu1_skew
);
  localparam int unsigned NBYTES = 1 << AW;
  localparam int unsigned PAD    = 8 - STRAP_W;

  logic [7:0]         bank [NBYTES];
  logic [STRAP_W-1:0] strap_q;
  logic               strap_taken;
  logic [4:0]         strap_code;

  clkcfg_strap_capture #(.W(STRAP_W)) u_strap (
    .clk   (clk),
    .rst_n (rst_n),
    .pins  (strap_in),
    .held  (strap_q),
    .taken (strap_taken)
  );

  for (genvar g = 0; g < NBYTES; g++) begin : g_byte
    logic sel;
    assign sel = wr_en && (addr == AW'(g));
    clkcfg_reg_byte #(
      .RST  (byte_rst(g)),
      .MASK (byte_wmask(g))
    ) u_byte (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (sel),
      .wd    (wdata),
      .q     (bank[g])
    );
  end

  always_comb begin
    if (addr == AW'(STRAP_ADDR)) rdata = {{PAD{1'b0}}, strap_q};
    else                         rdata = bank[addr];
  end

  assign strap_code = 5'(strap_q);

  clkcfg_field_map u_map (
    .ctl4            (bank[4]),
    .stopc           (bank[6][5:0]),
    .pcien           (bank[7]),
    .perif           ({bank[9][7], bank[9][5:3], bank[9][0]}),
    .auxen           (bank[10][6:0]),
    .divc            (bank[13][2:0]),
    .nlo             (bank[14]),
    .mdiv            (bank[15][6:0]),
    .skew            (bank[18]),
    .strap           (strap_code[3:0]),
    .freq_code       (freq_code),
    .freq_from_regs  (freq_from_regs),
    .ssc_en          (ssc_en),
    .out_tristate    (out_tristate),
    .spread_down     (spread_down),
    .periph_48m      (periph_48m),
    .pd_pin_en       (pd_pin_en),
    .usb_oe          (usb_oe),
    .sio_oe          (sio_oe),
    .cpu0_stop_mask  (cpu0_stop_mask),
    .cpu1_stop_mask  (cpu1_stop_mask),
    .cpu0_oe         (cpu0_oe),
    .cpu1_oe         (cpu1_oe),
    .pcif0_stop_mask (pcif0_stop_mask),
    .pcif1_stop_mask (pcif1_stop_mask),
    .pci_oe          (pci_oe),
    .aux_oe          (aux_oe),
    .pll_n           (pll_n),
    .pll_m           (pll_m),
    .pll_from_div    (pll_from_div),
    .cpu0_skew       (cpu0_skew),
    .cpu1_skew       (cpu1_skew)
  );
endmodule

// File: rtl/clkcfg_regbank_chk.sv
module clkcfg_regbank_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [4:0] addr,
  input logic [7:0] rdata,
  input logic [3:0] strap_q,
  input logic       strap_taken,
  input logic       freq_from_regs,
  input logic [4:0] freq_code,
  input logic [3:0] cpu0_skew,
  input logic [3:0] cpu1_skew
);
  // R1
  resv_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr < 5'd4) |-> (rdata == 8'hFF));
  // R3
  strap_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 5'd5) |-> (rdata[7:4] == 4'h0));
  // R4
  strap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strap_taken && $past(strap_taken)) |-> $stable(strap_q));
  // R5
  id_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 5'd8) |-> (rdata == 8'hF1));
  // R6
  freq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !freq_from_regs |-> (freq_code == {1'b0, strap_q}));
  // R12
  skew_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu0_skew <= 4'd8) && (cpu1_skew <= 4'd8));
  // R13
  hole_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr > 5'd22) |-> (rdata == 8'h00));
endmodule

bind clkcfg_regbank clkcfg_regbank_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .addr           (addr),
  .rdata          (rdata),
  .strap_q        (strap_q),
  .strap_taken    (strap_taken),
  .freq_from_regs (freq_from_regs),
  .freq_code      (freq_code),
  .cpu0_skew      (cpu0_skew),
  .cpu1_skew      (cpu1_skew)
);

// File: tb/clkcfg_regbank_tb.sv
module clkcfg_regbank_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] strap_in = 4'h0;
  logic       wr_en = 1'b0;
  logic [4:0] addr = 5'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic [4:0] freq_code;
  logic freq_from_regs, ssc_en, out_tristate, spread_down, periph_48m, pd_pin_en;
  logic usb_oe, sio_oe, cpu0_stop_mask, cpu1_stop_mask, cpu0_oe, cpu1_oe;
  logic pcif0_stop_mask, pcif1_stop_mask, pll_from_div;
  logic [7:0] pci_oe;
  logic [6:0] aux_oe;
  logic [9:0] pll_n;
  logic [6:0] pll_m;
  logic [3:0] cpu0_skew, cpu1_skew;

  int compared = 0;
  int mismatched = 0;
  logic [7:0] sh [32];

  always #10 clk = ~clk;

  clkcfg_regbank u_dut (
    .clk(clk), .rst_n(rst_n), .strap_in(strap_in), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .freq_code(freq_code),
    .freq_from_regs(freq_from_regs), .ssc_en(ssc_en), .out_tristate(out_tristate),
    .spread_down(spread_down), .periph_48m(periph_48m), .pd_pin_en(pd_pin_en),
    .usb_oe(usb_oe), .sio_oe(sio_oe), .cpu0_stop_mask(cpu0_stop_mask),
    .cpu1_stop_mask(cpu1_stop_mask), .cpu0_oe(cpu0_oe), .cpu1_oe(cpu1_oe),
    .pcif0_stop_mask(pcif0_stop_mask), .pcif1_stop_mask(pcif1_stop_mask),
    .pci_oe(pci_oe), .aux_oe(aux_oe), .pll_n(pll_n), .pll_m(pll_m),
    .pll_from_div(pll_from_div), .cpu0_skew(cpu0_skew), .cpu1_skew(cpu1_skew)
  );

  // Reset values per R1 (bytes 5 and 8 handled separately: R3, R5)
  function automatic logic [7:0] m_rst(int a);
    if (a <= 3) return 8'hFF;
    unique case (a)
      6: return 8'h0B;   7: return 8'hFF;  8: return 8'hF1;  9: return 8'hB0;
      10: return 8'h7F;  11: return 8'h3F; 18: return 8'h44; 19: return 8'h40;
      default: return 8'h00;
    endcase
  endfunction

  // Writable masks per R2
  function automatic logic [7:0] m_mask(int a);
    unique case (a)
      4, 7, 14, 18: return 8'hFF;
      6: return 8'h3F;   9: return 8'hB9;  10: return 8'h7F;
      13: return 8'h07;  15: return 8'h7F;
      default: return 8'h00;
    endcase
  endfunction

  function automatic string tag_of(int a);
    if (a <= 3) return "R1";
    if (a == 5) return "R3";
    if (a == 8) return "R5";
    if (a >= 23) return "R13";
    return "R2";
  endfunction

  task automatic cmp(string tag, int act, int exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(int a, logic [7:0] d);
    @(negedge clk);
    addr = 5'(a); wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    if (!(a == 5 || a == 8)) sh[a] = (d & m_mask(a)) | (m_rst(a) & ~m_mask(a));
  endtask

  task automatic rd_chk(int a);
    @(negedge clk);
    addr = 5'(a); wr_en = 1'b0;
    #1;
    cmp(tag_of(a), rdata, sh[a]);
  endtask

  task automatic do_reset(logic [3:0] s);
    @(negedge clk);
    rst_n = 1'b0; strap_in = s;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);          // capture edge has passed
    strap_in = ~s;           // R4: later pin changes must not show
    for (int a = 0; a < 32; a++) sh[a] = m_rst(a);
    sh[5] = {4'h0, s};
  endtask

  task automatic fields_chk();
    logic [4:0] fexp;
    logic [3:0] k0, k1;
    @(negedge clk); #1;
    fexp = sh[4][3] ? {sh[4][2], sh[4][7:4]} : {1'b0, sh[5][3:0]};
    cmp("R6 freq_code", freq_code, fexp);
    cmp("R6 freq_from_regs", freq_from_regs, sh[4][3]);
    cmp("R7 ssc_en", ssc_en, !sh[4][1]);
    cmp("R7 out_tristate", out_tristate, sh[4][0]);
    cmp("R8 periph fields",
        {pd_pin_en, usb_oe, sio_oe, periph_48m, spread_down},
        {sh[9][7], sh[9][5], sh[9][4], sh[9][3], sh[9][0]});
    cmp("R9 stop/oe",
        {pcif0_stop_mask, pcif1_stop_mask, cpu0_stop_mask, cpu1_stop_mask, cpu0_oe, cpu1_oe},
        sh[6][5:0]);
    cmp("R10 pci_oe", pci_oe, sh[7]);
    cmp("R10 aux_oe", aux_oe, sh[10][6:0]);
    cmp("R11 pll_n", pll_n, sh[13][1:0] * 256 + sh[14]);
    cmp("R11 pll_m", pll_m, sh[15][6:0]);
    cmp("R11 pll_from_div", pll_from_div, sh[13][2]);
    k0 = sh[18][7:4]; k1 = sh[18][3:0];
    cmp("R12 cpu0_skew", cpu0_skew, (k0 > 8) ? 8 : k0);
    cmp("R12 cpu1_skew", cpu1_skew, (k1 > 8) ? 8 : k1);
  endtask

  logic done = 1'b0;

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [7:0] pats [4];
    pats[0] = 8'hFF; pats[1] = 8'h00; pats[2] = 8'hA5; pats[3] = 8'h5A;

    do_reset(4'b1010);
    // R1 R3 R4 R5 R13: every byte after reset
    for (int a = 0; a < 32; a++) rd_chk(a);
    fields_chk();

    // R2 R3 R5 R13: full-address sweeps with several patterns
    foreach (pats[p]) begin
      for (int a = 0; a < 32; a++) wr(a, pats[p] ^ 8'(a));
      for (int a = 0; a < 32; a++) rd_chk(a);
      fields_chk();
    end

    // R6: both frequency code sources
    wr(4, 8'b1011_0100);
    fields_chk();
    wr(4, 8'b1011_1100);
    fields_chk();
    wr(4, 8'b0100_1011);
    fields_chk();

    // R12: exhaustive skew codes on both nibbles, clamp at 8
    for (int c = 0; c < 16; c++) begin
      wr(18, {4'(c), 4'(15 - c)});
      fields_chk();
    end

    // R11: divider extremes
    wr(13, 8'hFF); wr(14, 8'hFF); wr(15, 8'hFF);
    fields_chk();

    // R4: second reset with complementary straps, register source off
    do_reset(4'b0101);
    rd_chk(5);
    fields_chk();
    repeat (5) @(negedge clk);
    rd_chk(5);
    cmp("R4 freq_code held", freq_code, 5'b00101);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule